// File: doc/BRIEF.md
# Out-of-order wakeup-and-select issue scheduler

This block holds renamed operations that are waiting for their operands and sends each one to its functional unit once the operands are known to be ready. There is one adder with a four-cycle execute latency and one multiplier with a six-cycle latency. Each unit has its own four-entry waiting station and is fed through a single issue port. An entry stores its destination tag and two source tags, and each source tag carries a ready flag. A unit announces the destination tag of its current operation on its own broadcast bus one cycle before the result exists. Every waiting entry compares both broadcast buses against its source tags and sets the ready flag of each match. A dependent operation can therefore start in the first cycle the result is available.

Each cycle, a station whose unit is idle sends out its oldest entry that has both sources ready. Age comes from a dispatch sequence number stored in each entry, and the comparison tolerates wraparound of that number. The dispatch port takes one operation per cycle. It signals back pressure when the station for the offered operation type is full, even if the other station has room. A flush empties both stations, stops the operations in flight and cancels every broadcast still due.

Top module: `wakeup_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, no issue and no broadcast are signalled and `disp_ready` is 1.
- R2: A source tag of 0 is always ready. A source with its dispatch ready flag set is ready. A waiting source becomes ready in the cycle after either broadcast bus carries a matching valid tag.
- R3: A broadcast in the same cycle as a dispatch wakes the new entry, so that entry can issue in the next cycle.
- R4: Each unit issues at most one operation per cycle. When several entries are eligible, the one dispatched earliest is issued.
- R5: A unit is not pipelined. After an issue in cycle T, the next issue to the adder comes no earlier than T+4, and to the multiplier no earlier than T+6.
- R6: An operation issued in cycle T on a unit of latency L has its destination tag broadcast on that unit's bus in exactly cycle T+L-1, and in no other cycle.
- R7: An entry dispatched in cycle D can issue no earlier than D+1. An eligible entry is issued in every cycle its unit is free, so no issue cycle is lost.
- R8: `disp_ready` is 1 exactly when the station for the offered type has fewer than 4 live entries (`disp_is_mul`=1 selects the multiplier). An entry frees at the clock edge ending its issue cycle, and a full station does not block the other type.
- R9: In a cycle with `flush` high, no issue or broadcast is signalled and dispatch is ignored. After that cycle both stations are empty, both units are idle, and no pending broadcast ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop all waiting and in-flight work |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_is_mul | input | 1 | 1 = multiply operation, 0 = add operation |
| disp_dst | input | TAG_W | Destination tag of the dispatched operation |
| disp_src1 | input | TAG_W | First source tag (0 = none) |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src2 | input | TAG_W | Second source tag (0 = none) |
| disp_src2_rdy | input | 1 | Second source already available |
| disp_ready | output | 1 | Station for the offered type can accept |
| add_iss_valid | output | 1 | Adder issue this cycle |
| add_iss_dst | output | TAG_W | Destination tag issued to the adder |
| add_iss_src1 | output | TAG_W | First source tag issued to the adder |
| add_iss_src2 | output | TAG_W | Second source tag issued to the adder |
| mul_iss_valid | output | 1 | Multiplier issue this cycle |
| mul_iss_dst | output | TAG_W | Destination tag issued to the multiplier |
| mul_iss_src1 | output | TAG_W | First source tag issued to the multiplier |
| mul_iss_src2 | output | TAG_W | Second source tag issued to the multiplier |
| add_bc_valid | output | 1 | Adder early tag broadcast valid |
| add_bc_tag | output | TAG_W | Adder broadcast tag |
| mul_bc_valid | output | 1 | Multiplier early tag broadcast valid |
| mul_bc_tag | output | TAG_W | Multiplier broadcast tag |

## Verification
Three things can fall in the same cycle: a broadcast and the dispatch of an operation that consumes it, a wakeup and an issue decision in the same station, and a flush and a broadcast that is due. A directed case dispatches a consumer exactly in its producer's broadcast cycle and requires it to issue one cycle later. Random dependent batches, cut short by flushes at random times, are compared cycle by cycle against a bench model. That model derives eligibility, age order, unit occupancy and broadcast timing from the requirements alone. A separate directed case flushes while a multiply is in flight and requires that its broadcast never appears.

// File: rtl/sched_pkg.sv
package sched_pkg;
   localparam int SEQ_W = 8;
   typedef logic [SEQ_W-1:0] seq_t;

   // a is older than b when (a - b) is negative modulo 2**SEQ_W
   function automatic logic seq_older(seq_t a, seq_t b);
      seq_t d;
      d = a - b;
      return d[SEQ_W-1];
   endfunction
endpackage

// File: rtl/sched_station.sv
module sched_station
   import sched_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 6,
   parameter int NBC     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        wr_en,
   input  logic [TAG_W-1:0]            wr_dst,
   input  logic [TAG_W-1:0]            wr_s1,
   input  logic                        wr_r1,
   input  logic [TAG_W-1:0]            wr_s2,
   input  logic                        wr_r2,
   input  seq_t                        wr_seq,
   input  logic [NBC-1:0]              bc_v,
   input  logic [NBC-1:0][TAG_W-1:0]   bc_tag,
   input  logic                        unit_free,
   output logic                        full,
   output logic                        iss_v,
   output logic [TAG_W-1:0]            iss_dst,
   output logic [TAG_W-1:0]            iss_s1,
   output logic [TAG_W-1:0]            iss_s2
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 1) begin : g_bad_depth
      $error("sched_station: ENTRIES must be at least 1");
   end

   logic [ENTRIES-1:0] valid_q, rdy1_q, rdy2_q, cand, grant;
   logic [TAG_W-1:0]   dst_q [ENTRIES];
   logic [TAG_W-1:0]   s1_q  [ENTRIES];
   logic [TAG_W-1:0]   s2_q  [ENTRIES];
   seq_t               seq_q [ENTRIES];
   logic [IDX_W-1:0]   alloc_idx;
   logic               alloc_go;

   function automatic logic tag_hit(logic [TAG_W-1:0] t, logic [NBC-1:0] bv,
                                    logic [NBC-1:0][TAG_W-1:0] bt);
      logic h;
      h = (t == '0);
      for (int k = 0; k < NBC; k++)
         if (bv[k] && bt[k] == t) h = 1'b1;
      return h;
   endfunction

   // first free slot
   always_comb begin
      logic found;
      found     = 1'b0;
      alloc_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid_q[i] && !found) begin
            alloc_idx = IDX_W'(i);
            found     = 1'b1;
         end
      end
   end

   assign full     = &valid_q;
   assign alloc_go = wr_en && !full;
   assign cand     = valid_q & rdy1_q & rdy2_q;

   // oldest-ready select: an entry wins when no other candidate is older
   for (genvar i = 0; i < ENTRIES; i++) begin : g_age
      logic win;
      always_comb begin
         win = cand[i];
         for (int j = 0; j < ENTRIES; j++)
            if (j != i && cand[j] && seq_older(seq_q[j], seq_q[i])) win = 1'b0;
      end
      assign grant[i] = win;
   end

   assign iss_v = (|grant) && unit_free && !flush;

   always_comb begin
      iss_dst = '0;
      iss_s1  = '0;
      iss_s2  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (grant[i]) begin
            iss_dst = iss_dst | dst_q[i];
            iss_s1  = iss_s1  | s1_q[i];
            iss_s2  = iss_s2  | s2_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++)
            if (grant[i] && iss_v) valid_q[i] <= 1'b0;
         if (alloc_go) valid_q[alloc_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         rdy1_q[i] <= rdy1_q[i] | tag_hit(s1_q[i], bc_v, bc_tag);
         rdy2_q[i] <= rdy2_q[i] | tag_hit(s2_q[i], bc_v, bc_tag);
      end
      if (alloc_go) begin
         dst_q[alloc_idx]  <= wr_dst;
         s1_q[alloc_idx]   <= wr_s1;
         s2_q[alloc_idx]   <= wr_s2;
         seq_q[alloc_idx]  <= wr_seq;
         rdy1_q[alloc_idx] <= wr_r1 | tag_hit(wr_s1, bc_v, bc_tag);
         rdy2_q[alloc_idx] <= wr_r2 | tag_hit(wr_s2, bc_v, bc_tag);
      end
   end

   // R4
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   for (genvar i = 0; i < ENTRIES; i++) begin : g_sticky
      // R2
      ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q[i] && rdy1_q[i] && !flush) |=> (rdy1_q[i] || !valid_q[i]));
   end
endmodule

// File: rtl/sched_exec_timer.sv
module sched_exec_timer #(
   parameter int LAT   = 4,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             start,
   input  logic [TAG_W-1:0] start_tag,
   output logic             free,
   output logic             bc_v,
   output logic [TAG_W-1:0] bc_tag
);
   localparam int CW = $clog2(LAT + 1);

   if (LAT < 2) begin : g_bad_lat
      $error("sched_exec_timer: LAT must be at least 2 for early broadcast");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (flush)            cnt_q <= '0;
      else if (start)            cnt_q <= CW'(LAT - 1);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (start) bc_tag <= start_tag;
   end

   assign free = (cnt_q == '0);
   // broadcast in the last execute cycle, one cycle ahead of the result
   assign bc_v = (cnt_q == CW'(1)) && !flush;

   // R5
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !free);
   // R6
   free_after_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bc_v |=> free);
endmodule

// File: rtl/wakeup_sched.sv
module wakeup_sched
   import sched_pkg::*;
#(
   parameter int TAG_W   = 6,
   parameter int ENTRIES = 4,
   parameter int ADD_LAT = 4,
   parameter int MUL_LAT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             disp_valid,
   input  logic             disp_is_mul,
   input  logic [TAG_W-1:0] disp_dst,
   input  logic [TAG_W-1:0] disp_src1,
   input  logic             disp_src1_rdy,
   input  logic [TAG_W-1:0] disp_src2,
   input  logic             disp_src2_rdy,
   output logic             disp_ready,
   output logic             add_iss_valid,
   output logic [TAG_W-1:0] add_iss_dst,
   output logic [TAG_W-1:0] add_iss_src1,
   output logic [TAG_W-1:0] add_iss_src2,
   output logic             mul_iss_valid,
   output logic [TAG_W-1:0] mul_iss_dst,
   output logic [TAG_W-1:0] mul_iss_src1,
   output logic [TAG_W-1:0] mul_iss_src2,
   output logic             add_bc_valid,
   output logic [TAG_W-1:0] add_bc_tag,
   output logic             mul_bc_valid,
   output logic [TAG_W-1:0] mul_bc_tag
);
   localparam int NU = 2;

   if (4 * ENTRIES > (1 << SEQ_W)) begin : g_bad_seq
      $error("wakeup_sched: sequence field too narrow for station depth");
   end

   logic [NU-1:0]            full, iss_v, free, bc_v;
   logic [NU-1:0][TAG_W-1:0] bc_tag, iss_dst, iss_s1, iss_s2;
   seq_t                     seq_q;
   logic                     accept;

   assign disp_ready = disp_is_mul ? !full[1] : !full[0];
   assign accept     = disp_valid && !flush && disp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seq_q <= '0;
      else if (accept) seq_q <= seq_q + 1'b1;
   end

   for (genvar u = 0; u < NU; u++) begin : g_unit
      localparam int LAT = (u == 0) ? ADD_LAT : MUL_LAT;
      logic wr_en;
      assign wr_en = disp_valid && !flush && (disp_is_mul == 1'(u));

      sched_station #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .NBC(NU)) u_rs (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .wr_en(wr_en), .wr_dst(disp_dst),
         .wr_s1(disp_src1), .wr_r1(disp_src1_rdy),
         .wr_s2(disp_src2), .wr_r2(disp_src2_rdy),
         .wr_seq(seq_q), .bc_v(bc_v), .bc_tag(bc_tag),
         .unit_free(free[u]), .full(full[u]), .iss_v(iss_v[u]),
         .iss_dst(iss_dst[u]), .iss_s1(iss_s1[u]), .iss_s2(iss_s2[u])
      );

      sched_exec_timer #(.LAT(LAT), .TAG_W(TAG_W)) u_tmr (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .start(iss_v[u]), .start_tag(iss_dst[u]),
         .free(free[u]), .bc_v(bc_v[u]), .bc_tag(bc_tag[u])
      );
   end

   assign add_iss_valid = iss_v[0];
   assign add_iss_dst   = iss_dst[0];
   assign add_iss_src1  = iss_s1[0];
   assign add_iss_src2  = iss_s2[0];
   assign mul_iss_valid = iss_v[1];
   assign mul_iss_dst   = iss_dst[1];
   assign mul_iss_src1  = iss_s1[1];
   assign mul_iss_src2  = iss_s2[1];
   assign add_bc_valid  = bc_v[0];
   assign add_bc_tag    = bc_tag[0];
   assign mul_bc_valid  = bc_v[1];
   assign mul_bc_tag    = bc_tag[1];

   // R9
   flush_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!add_bc_valid && !mul_bc_valid && !add_iss_valid && !mul_iss_valid));
endmodule

// File: tb/wakeup_sched_test.sv
`timescale 1ns/1ps
module wakeup_sched_test;
   localparam int TW = 6;
   localparam int NOT_YET = 1000000000;

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
   logic disp_valid = 1'b0, disp_is_mul = 1'b0;
   logic [TW-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
   logic disp_src1_rdy = 1'b0, disp_src2_rdy = 1'b0;
   logic disp_ready;
   logic add_iss_valid, mul_iss_valid, add_bc_valid, mul_bc_valid;
   logic [TW-1:0] add_iss_dst, add_iss_src1, add_iss_src2;
   logic [TW-1:0] mul_iss_dst, mul_iss_src1, mul_iss_src2;
   logic [TW-1:0] add_bc_tag, mul_bc_tag;

   wakeup_sched uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_is_mul(disp_is_mul), .disp_dst(disp_dst),
      .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
      .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy),
      .disp_ready(disp_ready),
      .add_iss_valid(add_iss_valid), .add_iss_dst(add_iss_dst),
      .add_iss_src1(add_iss_src1), .add_iss_src2(add_iss_src2),
      .mul_iss_valid(mul_iss_valid), .mul_iss_dst(mul_iss_dst),
      .mul_iss_src1(mul_iss_src1), .mul_iss_src2(mul_iss_src2),
      .add_bc_valid(add_bc_valid), .add_bc_tag(add_bc_tag),
      .mul_bc_valid(mul_bc_valid), .mul_bc_tag(mul_bc_tag)
   );

   always #4 clk = ~clk;   // 125 MHz

   int checks = 0, fails = 0;
   int cyc = 0;
   int bc_at [64];
   int obs_iss [64];
   int bc_seen = 0;
   int n = 0;
   int e_unit [256], e_dst [256], e_s1 [256], e_s2 [256], e_dc [256];
   bit e_live [256];
   int free_at [2], pbc_cyc [2], pbc_tag [2];

   function automatic int lat(int u);
      return (u == 0) ? 4 : 6;
   endfunction

   function automatic bit src_ok(int t, int c);
      return (t == 0) || (bc_at[t] < c);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic model_clear();
      n = 0;
      for (int u = 0; u < 2; u++) begin
         free_at[u] = 0; pbc_cyc[u] = -1; pbc_tag[u] = 0;
      end
      for (int t = 0; t < 64; t++) bc_at[t] = NOT_YET;
   endtask

   // one cycle: drive, compare against model, advance model
   task automatic step(input bit v, input bit m, input int d, input int s1,
                       input int s2, input bit fl, output bit acc);
      int cnt;
      int exp_k [2];
      bit exp_bc [2];
      flush = fl; disp_valid = v; disp_is_mul = m;
      disp_dst = TW'(d); disp_src1 = TW'(s1); disp_src2 = TW'(s2);
      disp_src1_rdy = src_ok(s1, cyc); disp_src2_rdy = src_ok(s2, cyc);
      #1;
      cnt = 0;
      for (int k = 0; k < n; k++) if (e_live[k] && e_unit[k] == int'(m)) cnt++;
      // R8
      chk(disp_ready == (cnt < 4), "R8 disp_ready", int'(disp_ready), int'(cnt < 4));
      for (int u = 0; u < 2; u++) begin
         bit av; int ad; bit bv; int bt;
         av = (u == 0) ? add_iss_valid : mul_iss_valid;
         ad = (u == 0) ? int'(add_iss_dst) : int'(mul_iss_dst);
         bv = (u == 0) ? add_bc_valid : mul_bc_valid;
         bt = (u == 0) ? int'(add_bc_tag) : int'(mul_bc_tag);
         exp_k[u] = -1;
         if (!fl && cyc >= free_at[u])
            for (int k = 0; k < n; k++)
               if (exp_k[u] < 0 && e_live[k] && e_unit[k] == u && e_dc[k] < cyc &&
                   src_ok(e_s1[k], cyc) && src_ok(e_s2[k], cyc))
                  exp_k[u] = k;
         // R4 R5 R7
         chk(av == (exp_k[u] >= 0), "R4/R5/R7 issue valid", int'(av), int'(exp_k[u] >= 0));
         if (av && exp_k[u] >= 0)
            chk(ad == e_dst[exp_k[u]], "R4 oldest issued", ad, e_dst[exp_k[u]]);
         if (av) obs_iss[ad] = cyc;
         if (bv) bc_seen++;
         exp_bc[u] = !fl && pbc_cyc[u] == cyc;
         // R6
         chk(bv == exp_bc[u], "R6 broadcast valid", int'(bv), int'(exp_bc[u]));
         if (bv && exp_bc[u])
            chk(bt == pbc_tag[u], "R6 broadcast tag", bt, pbc_tag[u]);
      end
      acc = 1'b0;
      if (fl) begin
         model_clear();
      end else begin
         for (int u = 0; u < 2; u++) begin
            if (exp_bc[u]) bc_at[pbc_tag[u]] = cyc;
            if (exp_k[u] >= 0) begin
               e_live[exp_k[u]] = 1'b0;
               free_at[u] = cyc + lat(u);
               pbc_cyc[u] = cyc + lat(u) - 1;
               pbc_tag[u] = e_dst[exp_k[u]];
            end
         end
         if (v && cnt < 4) begin
            acc = 1'b1;
            e_unit[n] = int'(m); e_dst[n] = d; e_s1[n] = s1; e_s2[n] = s2;
            e_dc[n] = cyc; e_live[n] = 1'b1; n++;
         end
      end
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input int k);
      bit a;
      for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0, a);
   endtask

   task automatic do_flush();
      bit a;
      step(0, 0, 0, 0, 0, 1, a);
   endtask

   task automatic dispatch(input bit m, input int d, input int s1, input int s2);
      bit a;
      a = 1'b0;
      while (!a) step(1, m, d, s1, s2, 0, a);
   endtask

   task automatic clear_obs();
      for (int t = 0; t < 64; t++) obs_iss[t] = -1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int base;
      int tb;
      bit a;
      void'($urandom(32'd1357));
      model_clear();
      clear_obs();
      repeat (3) @(negedge clk);
      #1;
      // R1 during reset
      chk(!add_iss_valid && !mul_iss_valid, "R1 no issue in reset", int'(add_iss_valid | mul_iss_valid), 0);
      chk(!add_bc_valid && !mul_bc_valid, "R1 no broadcast in reset", int'(add_bc_valid | mul_bc_valid), 0);
      chk(disp_ready == 1'b1, "R1 ready in reset", int'(disp_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);   // first cycles after reset checked against empty model (R1)

      // dependent exercise: MUL 1; ADD 2<-1; ADD 3; ADD 4; MUL 5<-3,4; ADD 6<-2,5
      clear_obs();
      base = cyc;
      dispatch(1, 1, 0, 0);
      dispatch(0, 2, 1, 0);
      dispatch(0, 3, 0, 0);
      dispatch(0, 4, 0, 0);
      dispatch(1, 5, 3, 4);
      dispatch(0, 6, 2, 5);
      idle(30);
      chk(obs_iss[1] - base == 1, "R7 mul1 issue cycle", obs_iss[1] - base, 1);
      chk(obs_iss[3] - base == 3, "R2 add3 tag-0 sources", obs_iss[3] - base, 3);
      chk(obs_iss[2] - base == 7, "R6 add2 woken by early bcast", obs_iss[2] - base, 7);
      chk(obs_iss[4] - base == 11, "R5 add4 waits for adder", obs_iss[4] - base, 11);
      chk(obs_iss[5] - base == 15, "R2 mul5 two producers", obs_iss[5] - base, 15);
      chk(obs_iss[6] - base == 21, "R6 add6 back to back", obs_iss[6] - base, 21);
      do_flush();

      // R3: dispatch consumer in producer's broadcast cycle
      clear_obs();
      dispatch(1, 1, 0, 0);
      while (pbc_cyc[1] != cyc) idle(1);
      tb = cyc;
      dispatch(0, 2, 1, 0);
      idle(6);
      chk(obs_iss[2] == tb + 1, "R3 same-cycle wakeup", obs_iss[2], tb + 1);
      do_flush();

      // R8: fill adder station behind a pending multiply
      dispatch(1, 1, 0, 0);
      for (int i = 0; i < 4; i++) dispatch(0, 2 + i, 1, 0);
      step(1, 0, 9, 0, 0, 0, a);
      chk(a == 1'b0, "R8 full adder station stalls", int'(a), 0);
      step(1, 1, 10, 0, 0, 0, a);
      chk(a == 1'b1, "R8 multiplier still accepts", int'(a), 1);
      do_flush();
      idle(1);

      // R9: flush with multiply in flight cancels its broadcast
      clear_obs();
      dispatch(1, 7, 0, 0);
      idle(3);
      chk(obs_iss[7] >= 0, "R9 setup mul issued", obs_iss[7], 1);
      do_flush();
      bc_seen = 0;
      idle(8);
      chk(bc_seen == 0, "R9 broadcast cancelled", bc_seen, 0);

      // random dependent batches cut by flushes
      for (int b = 0; b < 40; b++) begin
         int nb;
         nb = 6 + int'($urandom % 12);
         for (int i = 1; i <= nb; i++) begin
            int s1, s2;
            bit m;
            m  = 1'($urandom % 2);
            s1 = (i > 1 && ($urandom % 3) != 0) ? 1 + int'($urandom % (i - 1)) : 0;
            s2 = (i > 1 && ($urandom % 3) == 0) ? 1 + int'($urandom % (i - 1)) : 0;
            if ($urandom % 4 == 0) idle(1);
            dispatch(m, i, s1, s2);
         end
         idle(int'($urandom % 60));
         do_flush();
      end

      summary();
      $finish;
   end
endmodule